// File: doc/BRIEF.md
# Pulse-Distance Infrared Remote Decoder

This block turns a demodulated infrared remote stream, already sliced into chips and presented one chip per strobe, into data words. A transmission starts with a long unbroken on burst that wakes the decoder. After that, every on chip opens a symbol. The number of off chips before the next on chip gives the bit value: one off chip is a 0 and three off chips are a 1. Bits arrive least significant first. The packet closes when the line stays off for longer than an idle threshold. The last on chip before that silence is a closing mark and carries no data.

While a button is held, the remote repeats its packet with no new wake burst. The decoder stays armed between packets. It reports each finished packet as a right-justified word together with its bit count. It raises a repeat flag when the packet matches the one before it and no wake burst came in between. A malformed run length raises a one-cycle error pulse, drops the partial packet and sends the decoder back to hunting for a wake burst.

Top module: `rdx_top`

## Requirements
- R1: After reset, `pkt_valid_o`, `pkt_word_o`, `pkt_len_o`, `pkt_repeat_o` and `sym_err_o` are all zero.
- R2: Data symbols produce no packet and no error until an on run of at least `WAKE_MIN` chips has been seen. Such a run arms the decoder, and this also holds after an error.
- R3: While a packet is being received, an on chip followed by exactly one off chip and then an on chip yields a 0 bit. An on chip followed by exactly three off chips and then an on chip yields a 1 bit.
- R4: The first bit received lands in bit 0 of `pkt_word_o` and each later bit lands one position higher. Bits at and above `pkt_len_o` are zero.
- R5: A packet ends when `IDLE_RUN`+1 consecutive off chips are sampled. `pkt_valid_o` then pulses for one clock, and `pkt_len_o` gives the number of data bits, which is one less than the number of on chips in the packet. Outside that pulse the word and length hold their values.
- R6: Inside a packet, an off run other than 1 or 3 that ends in an on chip (2, or 4 to `IDLE_RUN`) pulses `sym_err_o` for one clock. No packet is reported, and the decoder returns to hunting.
- R7: Once armed, an on run of 2 to `WAKE_MIN`-1 chips pulses `sym_err_o` and returns the decoder to hunting.
- R8: Packets of up to `MAX_BITS` bits are reported in full. A data bit beyond `MAX_BITS` pulses `sym_err_o` and the packet is dropped.
- R9: `pkt_repeat_o` is 1 with a packet exactly when its word and length equal those of the previous reported packet and no wake burst or error occurred since then.
- R10: `line_i` is sampled only in cycles with `chip_stb_i` high. `pkt_valid_o` and `sym_err_o` only rise in the clock after a strobe.
- R11: Consecutive packets of different lengths sent without a wake burst between them are each decoded and reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_stb_i | input | 1 | High for one clock per chip; qualifies `line_i` |
| line_i | input | 1 | Demodulated line level, 1 = light on |
| pkt_valid_o | output | 1 | One-clock pulse when a packet is complete |
| pkt_word_o | output | MAX_BITS | Received word, right-justified, first bit in bit 0 |
| pkt_len_o | output | $clog2(MAX_BITS+1) | Number of data bits in the packet |
| pkt_repeat_o | output | 1 | Packet repeats the previous one with no wake between |
| sym_err_o | output | 1 | One-clock pulse on a malformed run |

## Verification
Random packets of random length and content are sent with random gaps between strobes and random line values while the strobe is low. This separates the decoding of bit order and bit value from any sampling of the line outside a strobe. The random mix chooses between fresh wakes, held-button repeats, new content without a wake, and a wake followed by old content. That mix shows whether the repeat flag follows the content comparison and is cleared by a wake burst. Directed streams cover the rest: symbols with no wake, a wake burst one chip short, off runs of 2 and 4, and packets of exactly `MAX_BITS` and `MAX_BITS`+1 bits. Each of these triggers a different error path or length boundary.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,  // waiting for a wake burst
    ST_GAP  = 2'd1,  // armed, waiting for the first mark of a packet
    ST_DATA = 2'd2   // collecting symbols
  } rdx_state_e;
endpackage

// File: rtl/rdx_run_tracker.sv
// Tracks on/off run lengths of the chip stream and flags edges and idle.
module rdx_run_tracker #(
  parameter int WAKE_MIN = 8,
  parameter int IDLE_RUN = 5,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          line_i,
  output logic          rise_o,
  output logic          fall_o,
  output logic          idle_o,
  output logic [CW-1:0] on_len_o,
  output logic [CW-1:0] off_len_o
);
  localparam logic [CW-1:0] ON_SAT  = CW'(WAKE_MIN);
  localparam logic [CW-1:0] OFF_SAT = CW'(IDLE_RUN + 1);
  localparam logic [CW-1:0] IDLE_AT = CW'(IDLE_RUN);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] on_q, on_d;
  logic [CW-1:0] off_q, off_d;

  assign rise_o    = stb_i & line_i & ~lvl_q;
  assign fall_o    = stb_i & ~line_i & lvl_q;
  assign idle_o    = stb_i & ~line_i & ~lvl_q & (off_q == IDLE_AT);
  assign on_len_o  = on_q;
  assign off_len_o = off_q;

  always_comb begin
    lvl_d = lvl_q;
    on_d  = on_q;
    off_d = off_q;
    if (stb_i) begin
      lvl_d = line_i;
      if (line_i) begin
        if (!lvl_q)              on_d = ONE;
        else if (on_q != ON_SAT) on_d = on_q + ONE;
      end else begin
        if (lvl_q)                 off_d = ONE;
        else if (off_q != OFF_SAT) off_d = off_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      on_q  <= '0;
      off_q <= OFF_SAT;
    end else begin
      lvl_q <= lvl_d;
      on_q  <= on_d;
      off_q <= off_d;
    end
  end
endmodule

// File: rtl/rdx_frame_asm.sv
// Collects bits from the top of a shift register and publishes packets.
module rdx_frame_asm #(
  parameter int MAX_BITS = 32,
  parameter int LW       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                shift_i,
  input  logic                bit_i,
  input  logic                emit_i,
  input  logic                fresh_i,
  output logic                full_o,
  output logic                empty_o,
  output logic                vld_o,
  output logic [MAX_BITS-1:0] word_o,
  output logic [LW-1:0]       len_o,
  output logic                rep_o
);
  localparam logic [LW-1:0] FULL = LW'(MAX_BITS);

  logic [MAX_BITS-1:0] sh_q, sh_d, last_w_q, last_w_d, word_q, word_d, aligned;
  logic [LW-1:0]       cnt_q, cnt_d, last_l_q, last_l_d, len_q, len_d;
  logic                fresh_q, fresh_d, vld_q, vld_d, rep_q, rep_d, same;

  assign aligned = sh_q >> (LW'(MAX_BITS) - cnt_q);
  assign same    = ~fresh_q & (aligned == last_w_q) & (cnt_q == last_l_q);
  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign vld_o   = vld_q;
  assign word_o  = word_q;
  assign len_o   = len_q;
  assign rep_o   = rep_q;

  always_comb begin
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    last_w_d = last_w_q;
    last_l_d = last_l_q;
    fresh_d  = fresh_q;
    word_d   = word_q;
    len_d    = len_q;
    rep_d    = rep_q;
    vld_d    = 1'b0;
    if (clr_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift_i) begin
      sh_d  = {bit_i, sh_q[MAX_BITS-1:1]};
      cnt_d = cnt_q + LW'(1);
    end
    if (emit_i) begin
      vld_d    = 1'b1;
      word_d   = aligned;
      len_d    = cnt_q;
      rep_d    = same;
      last_w_d = aligned;
      last_l_d = cnt_q;
      fresh_d  = 1'b0;
    end
    if (fresh_i) fresh_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      last_w_q <= '0;
      last_l_q <= '0;
      fresh_q  <= 1'b1;
      vld_q    <= 1'b0;
      word_q   <= '0;
      len_q    <= '0;
      rep_q    <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      last_w_q <= last_w_d;
      last_l_q <= last_l_d;
      fresh_q  <= fresh_d;
      vld_q    <= vld_d;
      word_q   <= word_d;
      len_q    <= len_d;
      rep_q    <= rep_d;
    end
  end
endmodule

// File: rtl/rdx_top.sv
module rdx_top #(
  parameter int MAX_BITS = 32,
  parameter int WAKE_MIN = 8,
  parameter int IDLE_RUN = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         chip_stb_i,
  input  logic                         line_i,
  output logic                         pkt_valid_o,
  output logic [MAX_BITS-1:0]          pkt_word_o,
  output logic [$clog2(MAX_BITS+1)-1:0] pkt_len_o,
  output logic                         pkt_repeat_o,
  output logic                         sym_err_o
);
  import rdx_pkg::*;

  localparam int RUN_MAX = (WAKE_MIN > IDLE_RUN + 1) ? WAKE_MIN : IDLE_RUN + 1;
  localparam int CW      = $clog2(RUN_MAX + 1);
  localparam int LW      = $clog2(MAX_BITS + 1);
  localparam logic [CW-1:0] RUN1 = CW'(1);
  localparam logic [CW-1:0] RUN3 = CW'(3);
  localparam logic [CW-1:0] WAKE = CW'(WAKE_MIN);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic          rise, fall, idle_hit;
  logic [CW-1:0] on_len, off_len;

  rdx_run_tracker #(.WAKE_MIN(WAKE_MIN), .IDLE_RUN(IDLE_RUN), .CW(CW)) u_runs (
    .clk(clk), .rst_n(rst_sync_n), .stb_i(chip_stb_i), .line_i(line_i),
    .rise_o(rise), .fall_o(fall), .idle_o(idle_hit),
    .on_len_o(on_len), .off_len_o(off_len)
  );

  rdx_state_e st_q, st_d;
  logic clr, sh_en, sh_bit, emit, fresh_set, err_d, err_q, full, empty;
  logic wake;

  assign wake = fall & (on_len >= WAKE);

  always_comb begin
    st_d      = st_q;
    clr       = 1'b0;
    sh_en     = 1'b0;
    sh_bit    = 1'b0;
    emit      = 1'b0;
    fresh_set = 1'b0;
    err_d     = 1'b0;
    if (wake) begin
      st_d      = ST_GAP;
      clr       = 1'b1;
      fresh_set = 1'b1;
    end else begin
      unique case (st_q)
        ST_GAP: begin
          if (fall) begin
            if (on_len == RUN1) begin
              st_d = ST_DATA;
              clr  = 1'b1;
            end else begin
              err_d = 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (fall && on_len != RUN1) begin
            err_d = 1'b1;
          end else if (rise) begin
            if ((off_len == RUN1 || off_len == RUN3) && !full) begin
              sh_en  = 1'b1;
              sh_bit = (off_len == RUN3);
            end else begin
              err_d = 1'b1;
            end
          end else if (idle_hit) begin
            st_d = ST_GAP;
            emit = ~empty;
          end
        end
        default: ;
      endcase
      if (err_d) begin
        st_d      = ST_HUNT;
        clr       = 1'b1;
        fresh_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_HUNT;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  rdx_frame_asm #(.MAX_BITS(MAX_BITS), .LW(LW)) u_frame (
    .clk(clk), .rst_n(rst_sync_n),
    .clr_i(clr), .shift_i(sh_en), .bit_i(sh_bit), .emit_i(emit),
    .fresh_i(fresh_set), .full_o(full), .empty_o(empty),
    .vld_o(pkt_valid_o), .word_o(pkt_word_o), .len_o(pkt_len_o),
    .rep_o(pkt_repeat_o)
  );

  assign sym_err_o = err_q;
endmodule

// File: rtl/rdx_chk.sv
module rdx_chk #(
  parameter int MAX_BITS = 32,
  parameter int LW       = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stb,
  input logic                vld,
  input logic [MAX_BITS-1:0] word,
  input logic [LW-1:0]       len,
  input logic                rep,
  input logic                err
);
  logic                have_q;
  logic [MAX_BITS-1:0] prev_w_q;
  logic [LW-1:0]       prev_l_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      prev_w_q <= '0;
      prev_l_q <= '0;
    end else if (vld) begin
      have_q   <= 1'b1;
      prev_w_q <= word;
      prev_l_q <= len;
    end
  end

  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (len != '0) && (len <= LW'(MAX_BITS)));
  p_word_justified_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((word >> len) == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> ($stable(word) && $stable(len)));
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld && err));
  p_after_chip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld || err) |-> $past(stb));
  p_repeat_same_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && rep) |-> (have_q && word == prev_w_q && len == prev_l_q));
endmodule

bind rdx_top rdx_chk #(.MAX_BITS(MAX_BITS), .LW($clog2(MAX_BITS+1))) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stb(chip_stb_i), .vld(pkt_valid_o),
  .word(pkt_word_o), .len(pkt_len_o), .rep(pkt_repeat_o), .err(sym_err_o)
);

// File: tb/tb_rdx_top.sv
module tb_rdx_top;
  localparam int MAXB = 32;
  localparam int WAKE = 8;
  localparam int IDLE = 5;
  localparam int LW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic line = 1'b0;
  logic            pkt_valid, pkt_repeat, sym_err;
  logic [MAXB-1:0] pkt_word;
  logic [LW-1:0]   pkt_len;

  always #2 clk = ~clk;  // 250 MHz

  rdx_top #(.MAX_BITS(MAXB), .WAKE_MIN(WAKE), .IDLE_RUN(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .chip_stb_i(stb), .line_i(line),
    .pkt_valid_o(pkt_valid), .pkt_word_o(pkt_word), .pkt_len_o(pkt_len),
    .pkt_repeat_o(pkt_repeat), .sym_err_o(sym_err)
  );

  int n_chk = 0, n_bad = 0;
  int n_pkt = 0, n_err = 0;
  logic [63:0] got_w;
  int got_l;
  logic got_r;
  bit done = 0;

  // monitor away from the active edge
  always @(negedge clk) begin
    if (pkt_valid) begin
      n_pkt++;
      got_w = 64'(pkt_word);
      got_l = int'(pkt_len);
      got_r = pkt_repeat;
    end
    if (sym_err) n_err++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // one chip; line is random while the strobe is low (R10)
  task automatic chip(input logic v);
    @(negedge clk);
    line = v;
    stb  = 1'b1;
    @(negedge clk);
    stb  = 1'b0;
    line = 1'($urandom % 2);
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic send_wake(input int n);
    repeat (n) chip(1'b1);
    repeat (1 + $urandom % 3) chip(1'b0);
  endtask

  task automatic send_idle();
    repeat (IDLE + 2 + $urandom % 3) chip(1'b0);
  endtask

  task automatic send_bits(input logic [63:0] w, input int n);
    chip(1'b1);
    for (int i = 0; i < n; i++) begin
      repeat (w[i] ? 3 : 1) chip(1'b0);
      chip(1'b1);  // opens next symbol or closes the packet
    end
  endtask

  task automatic expect_pkt(input int p0, input logic [63:0] w, input int l,
                            input logic r, input string req);
    check(n_pkt == p0 + 1, req, "packet count", 64'(n_pkt - p0), 64'd1);
    check(got_w == w, req, "word", got_w, w);
    check(got_l == l, req, "length", 64'(got_l), 64'(l));
    check(got_r == r, "R9", "repeat flag", 64'(got_r), 64'(r));
  endtask

  function automatic logic [63:0] mask(input int l);
    return (l >= 64) ? '1 : ((64'd1 << l) - 64'd1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    int p0, e0;
    logic [63:0] prev_w, w;
    int prev_l, l;
    bit fresh;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check({pkt_valid, pkt_word, pkt_len, pkt_repeat, sym_err} == '0, "R1",
          "outputs after reset", 64'(pkt_word), 64'd0);

    // R2 symbols without wake are ignored
    p0 = n_pkt; e0 = n_err;
    send_bits(64'h5, 4); send_idle();
    check(n_pkt == p0 && n_err == e0, "R2", "events without wake",
          64'(n_pkt - p0 + n_err - e0), 64'd0);

    // R3 R5 single one-bit packet
    p0 = n_pkt;
    send_wake(WAKE); send_bits(64'h1, 1); send_idle();
    expect_pkt(p0, 64'h1, 1, 1'b0, "R3");

    // R9 same packet held, no wake
    p0 = n_pkt;
    send_bits(64'h1, 1); send_idle();
    expect_pkt(p0, 64'h1, 1, 1'b1, "R9");

    // R4 R11 new length, first bit lands in bit 0
    p0 = n_pkt;
    send_bits(64'h5, 4); send_idle();
    expect_pkt(p0, 64'h5, 4, 1'b0, "R4");
    p0 = n_pkt;
    send_bits(64'h2, 9); send_idle();
    expect_pkt(p0, 64'h2, 9, 1'b0, "R11");

    // R7 on run one chip short of a wake while armed
    p0 = n_pkt; e0 = n_err;
    send_wake(WAKE - 1);
    check(n_err == e0 + 1, "R7", "error on short burst", 64'(n_err - e0), 64'd1);
    send_bits(64'h3, 2); send_idle();  // R2 hunting again after error
    check(n_pkt == p0, "R2", "no packet after error", 64'(n_pkt - p0), 64'd0);

    // R6 off run of 2
    p0 = n_pkt; e0 = n_err;
    send_wake(WAKE); chip(1); chip(0); chip(1); chip(0); chip(0); chip(1); send_idle();
    check(n_err == e0 + 1 && n_pkt == p0, "R6", "off run 2",
          64'(n_err - e0), 64'd1);
    // R6 off run of 4
    p0 = n_pkt; e0 = n_err;
    send_wake(WAKE + 3); chip(1); repeat (4) chip(0); chip(1); send_idle();
    check(n_err == e0 + 1 && n_pkt == p0, "R6", "off run 4",
          64'(n_err - e0), 64'd1);

    // R8 full width, then one bit too many
    p0 = n_pkt;
    send_wake(WAKE); send_bits(64'hFFFF_FFFF, MAXB); send_idle();
    expect_pkt(p0, 64'hFFFF_FFFF, MAXB, 1'b0, "R8");
    p0 = n_pkt; e0 = n_err;
    send_bits(64'h1_FFFF_FFFF, MAXB + 1); send_idle();
    check(n_err == e0 + 1 && n_pkt == p0, "R8", "overflow error",
          64'(n_err - e0), 64'd1);

    // R9 wake between identical packets clears repeat
    send_wake(WAKE); p0 = n_pkt;
    send_bits(64'hA5, 8); send_idle();
    expect_pkt(p0, 64'hA5, 8, 1'b0, "R9");
    send_wake(WAKE); p0 = n_pkt;
    send_bits(64'hA5, 8); send_idle();
    expect_pkt(p0, 64'hA5, 8, 1'b0, "R9");
    prev_w = 64'hA5; prev_l = 8; fresh = 0;

    // random mix, R3 R4 R9 R10 R11
    for (int it = 0; it < 40; it++) begin
      int k = $urandom % 4;
      logic r;
      if (k == 0 || k == 3) begin
        send_wake(WAKE + $urandom % 4);
        fresh = 1;
      end
      if (k == 1 || k == 3) begin
        w = prev_w; l = prev_l;
      end else begin
        l = 1 + $urandom % MAXB;
        w = {$urandom, $urandom} & mask(l);
      end
      r = !fresh && w == prev_w && l == prev_l;
      p0 = n_pkt;
      send_bits(w, l); send_idle();
      expect_pkt(p0, w, l, r, "R3");
      prev_w = w; prev_l = l; fresh = 0;
    end

    done = 1;
    finish_run();
  end
endmodule